// File: doc/BRIEF.md
# Sleep Mode and Clock Gating Controller

This block manages low-power states for a small microcontroller core. Software sets a sleep-enable bit and picks one of four modes with a two-bit code. The core then signals a sleep instruction with a one-cycle pulse. While the core is asleep, the block drives one clock enable per clock domain (CPU, flash, I/O, ADC, peripheral, PLL) and an enable for the main oscillator. It passes through only the interrupt requests that are legal wake sources in the latched mode.

When an accepted wake event or a reset request arrives, the block holds the CPU clock off. It first waits through a start-up delay, which is applied only if the oscillator had been stopped. It then adds a fixed four-cycle halt. After that it releases the CPU with a one-cycle pulse and a flag that says whether the core resumes after the sleep instruction or restarts from the reset vector.

Top module: `sleep_ctrl`

## Requirements
- R1: A sleep pulse while `sleep_en` is 0 has no effect: `asleep` stays 0 and all clock enables stay 1.
- R2: A sleep pulse with `sleep_en` at 1 enters sleep on the next edge. `asleep` becomes 1 and `cur_mode` shows the latched mode code (00 Idle, 01 ADC noise reduction, 10 power-down, 11 standby).
- R3: Clock enables are packed as bit 0 CPU, 1 flash, 2 I/O, 3 ADC, 4 peripheral, 5 PLL. While asleep they are 6'h3C in Idle, 6'h08 in ADC noise reduction, and 6'h00 in power-down and standby.
- R4: `osc_en` is 0 only while asleep in power-down. It is 1 in every other state.
- R5: Wake sources are packed as bit 0 external level, 1 external edge, 2 pin change, 3 ADC, 4 watchdog, 5 other I/O. Idle accepts all six. ADC noise reduction accepts bits 0, 2, 3 and 4. Power-down and standby accept bits 0, 2 and 4. Any other request leaves the block asleep.
- R6: An external level request wakes the block only after it has been sampled high on LVL_HOLD consecutive edges while asleep. A shorter pulse does not wake it.
- R7: From the edge that accepts a wake event, `cpu_go` pulses high exactly START_CYC+4 cycles later in power-down and 4 cycles later in the other modes. The CPU clock enable stays 0 until that same edge.
- R8: After a wake by interrupt, `restart` is 0 while `cpu_go` is high, meaning execution resumes.
- R9: A reset request wakes the block in every mode with the same delay as R7. `restart` is then 1 while `cpu_go` is high.
- R10: Changes to `mode_sel` while asleep do not change `cur_mode`, the clock enables or the wake qualification until the next sleep entry.
- R11: After reset the block is awake, all clock enables and `osc_en` are 1, and `cpu_go` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_en | input | 1 | Sleep-enable bit from the control register |
| mode_sel | input | 2 | Sleep mode code from the control register |
| sleep_pulse | input | 1 | One-cycle pulse: sleep instruction executed |
| irq_req | input | 6 | Enabled interrupt requests, one per wake source class |
| rst_req | input | 1 | Reset request (wakes from any mode) |
| clk_en | output | 6 | Per-domain clock enables |
| osc_en | output | 1 | Main oscillator enable |
| cpu_go | output | 1 | One-cycle pulse when the CPU is released |
| restart | output | 1 | 1 = restart from reset vector, 0 = resume |
| asleep | output | 1 | Block is in a sleep mode |
| cur_mode | output | 2 | Mode latched at the last sleep entry |

## Verification
Bad sequencer state shows up as a `cpu_go` pulse on the wrong cycle. The bench measures the release latency for every mode and wake source, so an off-by-one in the start-up or halt counter is caught on the first wake. A wrong latched mode or a wrong qualification mask shows at the ports in the same cycle as a wrong clock-enable pattern, or a few cycles later as a wake that should not happen or a missing wake. A faulty level-filter count shows as a wake one cycle early or late, or as a wake from a pulse that is too short.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  localparam int NDOM = 6;
  localparam int NSRC = 6;

  localparam int DOM_CPU = 0;
  localparam int SRC_LVL = 0;

  typedef enum logic [1:0] {
    MD_IDLE  = 2'b00,
    MD_ADCNR = 2'b01,
    MD_PDOWN = 2'b10,
    MD_STBY  = 2'b11
  } slp_mode_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_SLEEP,
    ST_START,
    ST_HALT
  } seq_st_e;

  // Wake sources accepted in each mode (bit order: lvl, edge, pin, adc, wdt, io)
  function automatic logic [NSRC-1:0] wake_mask(slp_mode_e m);
    case (m)
      MD_IDLE:  return 6'h3F;
      MD_ADCNR: return 6'h1D;
      default:  return 6'h15;
    endcase
  endfunction

  // Domain clocks running in each mode (bit order: cpu, flash, io, adc, pck, pll)
  function automatic logic [NDOM-1:0] dom_map(slp_mode_e m);
    case (m)
      MD_IDLE:  return 6'h3C;
      MD_ADCNR: return 6'h08;
      default:  return 6'h00;
    endcase
  endfunction
endpackage

// File: rtl/slp_wake_qual.sv
module slp_wake_qual
  import sleep_pkg::*;
#(
  parameter int LVL_HOLD = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleeping,
  input  slp_mode_e       mode,
  input  logic [NSRC-1:0] irq_req,
  output logic            wake
);
  localparam int CNTW = $clog2(LVL_HOLD + 1);
  localparam logic [CNTW-1:0] LVL_LAST = CNTW'(LVL_HOLD - 1);

  logic [CNTW-1:0] cnt_q, cnt_n;
  logic            lvl_ok;
  logic [NSRC-1:0] masked;

  always_comb begin
    cnt_n = cnt_q;
    if (!sleeping || !irq_req[SRC_LVL]) cnt_n = '0;
    else if (cnt_q != LVL_LAST)         cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  always_comb begin
    lvl_ok          = irq_req[SRC_LVL] && (cnt_q == LVL_LAST);
    masked          = irq_req & wake_mask(mode);
    masked[SRC_LVL] = lvl_ok && wake_mask(mode)[SRC_LVL];
    wake            = sleeping && (|masked);
  end
endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import sleep_pkg::*;
#(
  parameter int START_CYC = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_pulse,
  input  logic      sleep_en,
  input  slp_mode_e mode_sel,
  input  logic      wake_irq,
  input  logic      rst_req,
  output seq_st_e   state,
  output slp_mode_e mode_q,
  output logic      cpu_go,
  output logic      restart
);
  localparam int HALT_CYC = 4;
  localparam int CMAX     = (START_CYC > HALT_CYC) ? START_CYC : HALT_CYC;
  localparam int CW       = $clog2(CMAX + 1);
  localparam logic [CW-1:0] ST_LOAD = CW'((START_CYC > 0) ? START_CYC - 1 : 0);
  localparam logic [CW-1:0] HT_LOAD = CW'(HALT_CYC - 1);

  seq_st_e   st_q, st_n;
  slp_mode_e md_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic      go_n, rs_n;

  always_comb begin
    st_n  = st_q;
    md_n  = mode_q;
    cnt_n = cnt_q;
    go_n  = 1'b0;
    rs_n  = restart;
    case (st_q)
      ST_RUN: begin
        if (sleep_pulse && sleep_en) begin
          st_n = ST_SLEEP;
          md_n = mode_sel;
        end
      end
      ST_SLEEP: begin
        if (rst_req || wake_irq) begin
          rs_n = rst_req;
          if (mode_q == MD_PDOWN && START_CYC > 0) begin
            st_n  = ST_START;
            cnt_n = ST_LOAD;
          end else begin
            st_n  = ST_HALT;
            cnt_n = HT_LOAD;
          end
        end
      end
      ST_START: begin
        if (cnt_q == '0) begin
          st_n  = ST_HALT;
          cnt_n = HT_LOAD;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      default: begin
        if (cnt_q == '0) begin
          st_n = ST_RUN;
          go_n = 1'b1;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      mode_q  <= MD_IDLE;
      cnt_q   <= '0;
      cpu_go  <= 1'b0;
      restart <= 1'b0;
    end else begin
      st_q    <= st_n;
      mode_q  <= md_n;
      cnt_q   <= cnt_n;
      cpu_go  <= go_n;
      restart <= rs_n;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/slp_clk_map.sv
module slp_clk_map
  import sleep_pkg::*;
(
  input  seq_st_e         state,
  input  slp_mode_e       mode,
  output logic [NDOM-1:0] clk_en,
  output logic            osc_en
);
  always_comb begin
    clk_en = '1;
    osc_en = 1'b1;
    case (state)
      ST_SLEEP: begin
        clk_en = dom_map(mode);
        osc_en = (mode != MD_PDOWN);
      end
      ST_START: clk_en = '0;
      ST_HALT:  clk_en = dom_map(MD_IDLE);
      default:  clk_en = '1;
    endcase
  end
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_pkg::*;
#(
  parameter int START_CYC = 16,
  parameter int LVL_HOLD  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_en,
  input  logic [1:0] mode_sel,
  input  logic       sleep_pulse,
  input  logic [5:0] irq_req,
  input  logic       rst_req,
  output logic [5:0] clk_en,
  output logic       osc_en,
  output logic       cpu_go,
  output logic       restart,
  output logic       asleep,
  output logic [1:0] cur_mode
);
  seq_st_e   state;
  slp_mode_e mode_q;
  logic      wake_irq;
  logic      sleeping;

  assign sleeping = (state == ST_SLEEP);

  slp_wake_qual #(.LVL_HOLD(LVL_HOLD)) u_qual (
    .clk(clk), .rst_n(rst_n), .sleeping(sleeping), .mode(mode_q),
    .irq_req(irq_req), .wake(wake_irq)
  );

  slp_seq #(.START_CYC(START_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .sleep_pulse(sleep_pulse), .sleep_en(sleep_en),
    .mode_sel(slp_mode_e'(mode_sel)), .wake_irq(wake_irq), .rst_req(rst_req),
    .state(state), .mode_q(mode_q), .cpu_go(cpu_go), .restart(restart)
  );

  slp_clk_map u_map (
    .state(state), .mode(mode_q), .clk_en(clk_en), .osc_en(osc_en)
  );

  assign asleep   = sleeping;
  assign cur_mode = mode_q;
endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_en,
  input logic       sleep_pulse,
  input logic [5:0] irq_req,
  input logic       rst_req,
  input logic [5:0] clk_en,
  input logic       osc_en,
  input logic       cpu_go,
  input logic       asleep,
  input logic [1:0] cur_mode
);
  a_r1_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_pulse && !sleep_en && !asleep && clk_en[0]) |=> !asleep);

  a_r2_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_pulse && sleep_en && clk_en[0]) |=> asleep);

  a_r3_idle_map: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && cur_mode == 2'b00) |-> clk_en == 6'h3C);

  a_r4_pdown_osc: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && cur_mode == 2'b10) |-> (!osc_en && clk_en == 6'h00));

  a_r5_edge_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && cur_mode != 2'b00 && irq_req == 6'b000010 && !rst_req) |=> asleep);

  a_r7_cpu_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en[0]) |-> cpu_go);

  a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && $past(asleep)) |-> $stable(cur_mode));
endmodule

bind sleep_ctrl sleep_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .sleep_pulse(sleep_pulse),
  .irq_req(irq_req), .rst_req(rst_req), .clk_en(clk_en), .osc_en(osc_en),
  .cpu_go(cpu_go), .asleep(asleep), .cur_mode(cur_mode)
);

// File: tb/sleep_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_ctrl_tb;
  localparam int SC = 6;
  localparam int LH = 3;

  logic clk = 1'b0;
  logic rst_n, sleep_en, sleep_pulse, rst_req;
  logic [1:0] mode_sel;
  logic [5:0] irq_req;
  logic [5:0] clk_en;
  logic osc_en, cpu_go, restart, asleep;
  logic [1:0] cur_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  sleep_ctrl #(.START_CYC(SC), .LVL_HOLD(LH)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .mode_sel(mode_sel),
    .sleep_pulse(sleep_pulse), .irq_req(irq_req), .rst_req(rst_req),
    .clk_en(clk_en), .osc_en(osc_en), .cpu_go(cpu_go), .restart(restart),
    .asleep(asleep), .cur_mode(cur_mode)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_map(input int m);
    return (m == 0) ? 6'h3C : (m == 1) ? 6'h08 : 6'h00;
  endfunction

  function automatic bit exp_ok(input int m, input int s);
    if (m == 0) return 1;
    if (m == 1) return (s == 0 || s == 2 || s == 3 || s == 4);
    return (s == 0 || s == 2 || s == 4);
  endfunction

  task automatic enter(input int m);
    @(negedge clk);
    mode_sel = 2'(m); sleep_en = 1'b1; sleep_pulse = 1'b1;
    @(negedge clk);
    sleep_pulse = 1'b0; sleep_en = 1'b0; mode_sel = ~2'(m);
    chk(asleep == 1'b1, "R2 asleep", asleep, 1);
    chk(cur_mode == 2'(m), "R2 mode", cur_mode, m);
    chk(clk_en == exp_map(m), "R3 map", clk_en, exp_map(m));
    chk(osc_en == (m != 2), "R4 osc", osc_en, m != 2);
  endtask

  // Drive a source; count negedges until cpu_go (0 = none within limit)
  task automatic measure(input int lim, output int lat, output bit rs);
    lat = 0; rs = 0;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      if (cpu_go && lat == 0) begin lat = k; rs = restart; end
      if (lat == 0 && clk_en[0]) chk(0, "R7 cpu clock early", clk_en, 0);
    end
  endtask

  task automatic wake_by_reset(input int m);
    int lat; bit rs;
    @(negedge clk);
    rst_req = 1'b1;
    fork
      begin @(negedge clk); rst_req = 1'b0; end
    join_none
    lat = 0; rs = 0;
    for (int k = 1; k <= 30; k++) begin
      if (k > 1) @(negedge clk); else @(negedge clk);
      if (cpu_go && lat == 0) begin lat = k; rs = restart; end
    end
    chk(lat == 1 + ((m == 2) ? SC : 0) + 4, "R9 reset wake latency", lat, 1 + ((m == 2) ? SC : 0) + 4);
    chk(rs == 1'b1, "R9 restart flag", rs, 1);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat; bit rs; int hold; int exp_lat;
    rst_n = 1'b0; sleep_en = 0; sleep_pulse = 0; rst_req = 0;
    mode_sel = 0; irq_req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(clk_en == 6'h3F && osc_en, "R11 reset enables", clk_en, 6'h3F);
    chk(!asleep && !cpu_go, "R11 reset status", {asleep, cpu_go}, 0);

    // R1: pulse without enable
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      mode_sel = 2'(m); sleep_pulse = 1'b1; sleep_en = 1'b0;
      @(negedge clk);
      sleep_pulse = 1'b0;
      chk(!asleep && clk_en == 6'h3F, "R1 ignored pulse", {asleep, clk_en}, 6'h3F);
    end

    // Sweep every mode and every wake source
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 6; s++) begin
        enter(m);
        @(negedge clk);
        irq_req = 6'(1 << s);
        hold = (s == 0) ? LH : 1;
        exp_lat = hold + ((m == 2) ? SC : 0) + 4;
        if (exp_ok(m, s)) begin
          lat = 0; rs = 0;
          for (int k = 1; k <= exp_lat + 3; k++) begin
            @(negedge clk);
            if (cpu_go && lat == 0) begin lat = k; rs = restart; irq_req = '0; end
            if (lat == 0 && clk_en[0]) chk(0, "R7 cpu clock early", clk_en, 0);
          end
          irq_req = '0;
          chk(lat == exp_lat, $sformatf("R7 R5 latency m%0d s%0d", m, s), lat, exp_lat);
          chk(rs == 1'b0, "R8 resume flag", rs, 0);
        end else begin
          measure(exp_lat + 3, lat, rs);
          chk(lat == 0 && asleep, $sformatf("R5 blocked m%0d s%0d", m, s), lat, 0);
          chk(cur_mode == 2'(m) && clk_en == exp_map(m), "R10 mode held", cur_mode, m);
          irq_req = '0;
          wake_by_reset(m);
        end
      end
    end

    // R6: short level pulse in each mode does not wake
    for (int m = 0; m < 4; m++) begin
      enter(m);
      @(negedge clk);
      irq_req = 6'h01;
      repeat (LH - 1) @(negedge clk);
      irq_req = '0;
      measure(SC + 8, lat, rs);
      chk(lat == 0 && asleep, "R6 short level pulse", lat, 0);
      wake_by_reset(m);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule